// File: doc/BRIEF.md
# Word/Byte ALU with Status Flags

This block is the execution stage for the arithmetic, logic, move, shift and byte-immediate operations of a 16-bit processor. A decoder outside the block supplies an operation code, the current destination register value, a source operand (a register or a constant that has already been resolved), a word/byte select, an 8-bit immediate and a carry input. The block returns the new destination value and a destination write strobe in the same cycle. For the exchange operation it also returns a second value for the source register.

Four status bits (carry, zero, negative, overflow) live in a register inside the block. They change on the clock edge at which `valid` is high, and only for operations that affect status. In byte mode only the low eight bits take part in the operation. Flags are then taken from bit 7 and the carry out of bit 7, and the destination's upper byte is passed through unchanged.

Top module: `wb_alu`

## Requirements
- R1: With `op` 0 the result is dst+src, and with `op` 1 it is dst+src+`carryIn`. The registered carry becomes the carry out of the top bit of the active width.
- R2: With `op` 2 the result is dst+(~src)+1, and with `op` 3 it is dst+(~src)+`carryIn`. The carry is the carry out of that addition at the active width.
- R3: For the four add/subtract codes, overflow is set when both addends share a sign and the sum's sign differs from it. Logic codes (4–8), shifts (11, 12) and sign extension (14) clear overflow.
- R4: Zero and negative reflect the written or tested value at the active width, taking bit 7 or bit 15 as the sign. They appear on the flag outputs one clock after the `valid` cycle.
- R5: When `isByte` is 1, the byte-capable codes (0–9, 11, 12) compute on bits 7:0 only and return destination bits 15:8 unchanged.
- R6: Codes 4 (XOR), 5 (AND), 7 (dst AND NOT src) and 8 (OR) write their result and leave carry unchanged.
- R7: Code 6 forms dst AND src for the zero and negative flags only. `dstWrEn` stays low.
- R8: Code 11 shifts right one place, copying the sign bit. Code 12 rotates right one place, with `carryIn` entering the top bit. In both, the carry takes the bit shifted out of bit 0.
- R9: Code 13 swaps the two bytes of dst. Code 14 copies bit 7 into bits 15:8. Both ignore `isByte`.
- R10: Code 15 replaces the low byte with `imm`. Code 16 does the same and clears the high byte. Code 17 does the same and sets the high byte to 0xFF. Code 18 replaces only the high byte with `imm`.
- R11: Code 9 copies src to dst. Code 10 returns src as the result and dst on `srcResult`, with both `dstWrEn` and `srcWrEn` high.
- R12: Codes 9, 10, 13 and 15–18 leave all four flags unchanged, and so does any cycle with `valid` low.
- R13: Reset clears all four flags. While `valid` is low, both write strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Operation present this cycle |
| op | input | 5 | Operation code (0–18) |
| dstVal | input | 16 | Current destination value |
| srcVal | input | 16 | Source register or resolved constant |
| isByte | input | 1 | 1 selects byte width |
| imm | input | 8 | Byte immediate for codes 15–18 |
| carryIn | input | 1 | Incoming carry |
| result | output | 16 | New destination value |
| dstWrEn | output | 1 | Destination write strobe |
| srcResult | output | 16 | New source value (exchange) |
| srcWrEn | output | 1 | Source write strobe |
| flagC | output | 1 | Registered carry |
| flagZ | output | 1 | Registered zero |
| flagN | output | 1 | Registered negative |
| flagV | output | 1 | Registered overflow |

## Verification
The bench builds the block with its default word width of 16, which makes the byte lane 8 bits wide. This lets the directed cases reach both carry boundaries (0xFF+1 and 0xFFFF+1) and both signed-overflow boundaries (0x7F+1 and 0x7FFF+1). Random operands in both widths, with random carry inputs and idle cycles mixed in, are then compared against a behavioural model on every clock, together with the flag register the model carries.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD      = 5'd0,
    OP_ADDC     = 5'd1,
    OP_SUB      = 5'd2,
    OP_SUBC     = 5'd3,
    OP_XOR      = 5'd4,
    OP_AND      = 5'd5,
    OP_TEST     = 5'd6,
    OP_CLRBITS  = 5'd7,
    OP_SETBITS  = 5'd8,
    OP_MOVE     = 5'd9,
    OP_EXCH     = 5'd10,
    OP_ASR      = 5'd11,
    OP_RORC     = 5'd12,
    OP_BYTESWAP = 5'd13,
    OP_SEXT     = 5'd14,
    OP_LDLO     = 5'd15,
    OP_LDLOZ    = 5'd16,
    OP_LDLOS    = 5'd17,
    OP_LDHI     = 5'd18
  } alu_op_e;

  localparam int OP_W = 5;

  typedef enum logic [2:0] {
    FN_ADD,
    FN_XOR,
    FN_AND,
    FN_ANDN,
    FN_OR,
    FN_PASS,
    FN_ASR,
    FN_ROR
  } lane_fn_e;

  typedef enum logic [2:0] {
    RS_LANE,
    RS_BSWAP,
    RS_SEXT,
    RS_LDLO,
    RS_LDLOZ,
    RS_LDLOS,
    RS_LDHI
  } res_sel_e;

  typedef struct packed {
    lane_fn_e fn;
    logic     invertSrc;
    logic     useCarryIn;
    logic     byteCapable;
    res_sel_e resSel;
    logic     writeDst;
    logic     writeSrc;
    logic     updC;
    logic     updZN;
    logic     updV;
  } strobe_t;

endpackage

// File: rtl/alu_lane.sv
module alu_lane
  import alu_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  input  strobe_t      strb,
  output logic [N-1:0] res,
  output logic         cout,
  output logic         ovf
);
  logic [N-1:0] bOp;
  logic         cAdd;
  logic [N-1:0] sum;
  logic         addIn;

  assign bOp   = strb.invertSrc ? ~b : b;
  assign addIn = strb.useCarryIn ? cin : strb.invertSrc;
  assign {cAdd, sum} = {1'b0, a} + {1'b0, bOp} + {{N{1'b0}}, addIn};

  always_comb begin
    res  = b;
    cout = cin;
    ovf  = 1'b0;
    case (strb.fn)
      FN_ADD: begin
        res  = sum;
        cout = cAdd;
        ovf  = (a[N-1] == bOp[N-1]) && (sum[N-1] != a[N-1]);
      end
      FN_XOR:  res = a ^ b;
      FN_AND:  res = a & b;
      FN_ANDN: res = a & ~b;
      FN_OR:   res = a | b;
      FN_PASS: res = b;
      FN_ASR: begin
        res  = {a[N-1], a[N-1:1]};
        cout = a[0];
      end
      FN_ROR: begin
        res  = {cin, a[N-1:1]};
        cout = a[0];
      end
      default: res = b;
    endcase
  end
endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output strobe_t         strb
);
  alu_op_e opE;
  assign opE = alu_op_e'(op);

  always_comb begin
    strb = '{fn: FN_PASS, invertSrc: 1'b0, useCarryIn: 1'b0, byteCapable: 1'b0,
             resSel: RS_LANE, writeDst: 1'b0, writeSrc: 1'b0,
             updC: 1'b0, updZN: 1'b0, updV: 1'b0};
    case (opE)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: begin
        strb.fn          = FN_ADD;
        strb.invertSrc   = (opE == OP_SUB) || (opE == OP_SUBC);
        strb.useCarryIn  = (opE == OP_ADDC) || (opE == OP_SUBC);
        strb.byteCapable = 1'b1;
        strb.writeDst    = 1'b1;
        strb.updC        = 1'b1;
        strb.updZN       = 1'b1;
        strb.updV        = 1'b1;
      end
      OP_XOR, OP_AND, OP_CLRBITS, OP_SETBITS, OP_TEST: begin
        case (opE)
          OP_XOR:     strb.fn = FN_XOR;
          OP_CLRBITS: strb.fn = FN_ANDN;
          OP_SETBITS: strb.fn = FN_OR;
          default:    strb.fn = FN_AND;
        endcase
        strb.byteCapable = 1'b1;
        strb.writeDst    = (opE != OP_TEST);
        strb.updZN       = 1'b1;
        strb.updV        = 1'b1;
      end
      OP_MOVE: begin
        strb.byteCapable = 1'b1;
        strb.writeDst    = 1'b1;
      end
      OP_EXCH: begin
        strb.writeDst = 1'b1;
        strb.writeSrc = 1'b1;
      end
      OP_ASR, OP_RORC: begin
        strb.fn          = (opE == OP_ASR) ? FN_ASR : FN_ROR;
        strb.byteCapable = 1'b1;
        strb.writeDst    = 1'b1;
        strb.updC        = 1'b1;
        strb.updZN       = 1'b1;
        strb.updV        = 1'b1;
      end
      OP_BYTESWAP: begin
        strb.resSel   = RS_BSWAP;
        strb.writeDst = 1'b1;
      end
      OP_SEXT: begin
        strb.resSel   = RS_SEXT;
        strb.writeDst = 1'b1;
        strb.updZN    = 1'b1;
        strb.updV     = 1'b1;
      end
      OP_LDLO:  begin strb.resSel = RS_LDLO;  strb.writeDst = 1'b1; end
      OP_LDLOZ: begin strb.resSel = RS_LDLOZ; strb.writeDst = 1'b1; end
      OP_LDLOS: begin strb.resSel = RS_LDLOS; strb.writeDst = 1'b1; end
      OP_LDHI:  begin strb.resSel = RS_LDHI;  strb.writeDst = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_dpath.sv
module alu_dpath
  import alu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                valid,
  input  strobe_t             strb,
  input  logic [WORD_W-1:0]   dstVal,
  input  logic [WORD_W-1:0]   srcVal,
  input  logic                isByte,
  input  logic [WORD_W/2-1:0] imm,
  input  logic                carryIn,
  output logic [WORD_W-1:0]   result,
  output logic                dstWrEn,
  output logic [WORD_W-1:0]   srcResult,
  output logic                srcWrEn,
  output logic                flagC,
  output logic                flagZ,
  output logic                flagN,
  output logic                flagV
);
  localparam int HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] byteRes;
  logic              byteCout, byteOvf;
  logic [WORD_W-1:0] wordRes;
  logic              wordCout, wordOvf;
  logic              byteMode;
  logic [WORD_W-1:0] laneRes;
  logic              selCout, selOvf, selZero, selNeg;

  alu_lane #(.N(HALF_W)) u_byteLane (
    .a(dstVal[HALF_W-1:0]), .b(srcVal[HALF_W-1:0]), .cin(carryIn), .strb(strb),
    .res(byteRes), .cout(byteCout), .ovf(byteOvf)
  );

  alu_lane #(.N(WORD_W)) u_wordLane (
    .a(dstVal), .b(srcVal), .cin(carryIn), .strb(strb),
    .res(wordRes), .cout(wordCout), .ovf(wordOvf)
  );

  assign byteMode = isByte && strb.byteCapable;
  assign laneRes  = byteMode ? {dstVal[WORD_W-1:HALF_W], byteRes} : wordRes;

  always_comb begin
    case (strb.resSel)
      RS_BSWAP: result = {dstVal[HALF_W-1:0], dstVal[WORD_W-1:HALF_W]};
      RS_SEXT:  result = {{HALF_W{dstVal[HALF_W-1]}}, dstVal[HALF_W-1:0]};
      RS_LDLO:  result = {dstVal[WORD_W-1:HALF_W], imm};
      RS_LDLOZ: result = {{HALF_W{1'b0}}, imm};
      RS_LDLOS: result = {{HALF_W{1'b1}}, imm};
      RS_LDHI:  result = {imm, dstVal[HALF_W-1:0]};
      default:  result = laneRes;
    endcase
  end

  assign selCout = byteMode ? byteCout : wordCout;
  assign selOvf  = (strb.resSel == RS_LANE) && (byteMode ? byteOvf : wordOvf);
  assign selZero = byteMode ? (result[HALF_W-1:0] == '0) : (result == '0);
  assign selNeg  = byteMode ? result[HALF_W-1] : result[WORD_W-1];

  assign dstWrEn   = valid && strb.writeDst;
  assign srcWrEn   = valid && strb.writeSrc;
  assign srcResult = dstVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagC <= 1'b0;
      flagZ <= 1'b0;
      flagN <= 1'b0;
      flagV <= 1'b0;
    end else if (valid) begin
      if (strb.updC) flagC <= selCout;
      if (strb.updZN) begin
        flagZ <= selZero;
        flagN <= selNeg;
      end
      if (strb.updV) flagV <= selOvf;
    end
  end
endmodule

// File: rtl/wb_alu.sv
module wb_alu
  import alu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                valid,
  input  logic [4:0]          op,
  input  logic [WORD_W-1:0]   dstVal,
  input  logic [WORD_W-1:0]   srcVal,
  input  logic                isByte,
  input  logic [WORD_W/2-1:0] imm,
  input  logic                carryIn,
  output logic [WORD_W-1:0]   result,
  output logic                dstWrEn,
  output logic [WORD_W-1:0]   srcResult,
  output logic                srcWrEn,
  output logic                flagC,
  output logic                flagZ,
  output logic                flagN,
  output logic                flagV
);
  strobe_t strb;

  alu_ctrl u_ctrl (.op(op), .strb(strb));

  alu_dpath #(.WORD_W(WORD_W)) u_dpath (
    .clk(clk), .rstN(rstN), .valid(valid), .strb(strb),
    .dstVal(dstVal), .srcVal(srcVal), .isByte(isByte), .imm(imm),
    .carryIn(carryIn), .result(result), .dstWrEn(dstWrEn),
    .srcResult(srcResult), .srcWrEn(srcWrEn),
    .flagC(flagC), .flagZ(flagZ), .flagN(flagN), .flagV(flagV)
  );
endmodule

// File: rtl/wb_alu_chk.sv
module wb_alu_chk
  import alu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              valid,
  input logic [4:0]        op,
  input logic [WORD_W-1:0] dstVal,
  input logic [WORD_W-1:0] srcVal,
  input logic              isByte,
  input logic [WORD_W-1:0] result,
  input logic              dstWrEn,
  input logic [WORD_W-1:0] srcResult,
  input logic              srcWrEn,
  input logic              flagC,
  input logic              flagZ,
  input logic              flagN,
  input logic              flagV
);
  localparam int HALF_W = WORD_W / 2;
  alu_op_e opE;
  assign opE = alu_op_e'(op);

  a_r7_test_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opE == OP_TEST) |-> !dstWrEn);

  a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    (valid && isByte && (opE inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_XOR, OP_AND,
      OP_CLRBITS, OP_SETBITS, OP_MOVE, OP_ASR, OP_RORC}))
    |-> (result[WORD_W-1:HALF_W] == dstVal[WORD_W-1:HALF_W]));

  a_r12_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!valid || (opE inside {OP_MOVE, OP_EXCH, OP_BYTESWAP, OP_LDLO, OP_LDLOZ, OP_LDLOS, OP_LDHI}))
    |=> $stable({flagC, flagZ, flagN, flagV}));

  a_r3_logic_clears_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (valid && (opE inside {OP_XOR, OP_AND, OP_TEST, OP_CLRBITS, OP_SETBITS, OP_ASR, OP_RORC, OP_SEXT}))
    |=> !flagV);

  a_r10_ldloz_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opE == OP_LDLOZ) |-> (result[WORD_W-1:HALF_W] == '0));

  a_r11_exch_pair: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opE == OP_EXCH) |-> (result == srcVal && srcResult == dstVal && srcWrEn && dstWrEn));

  a_r13_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !valid |-> (!dstWrEn && !srcWrEn));

  a_r4_zero_word: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !isByte && (opE inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_XOR, OP_AND, OP_SETBITS}))
    |=> (flagZ == ($past(result) == '0)));
endmodule

bind wb_alu wb_alu_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .valid(valid), .op(op), .dstVal(dstVal), .srcVal(srcVal),
  .isByte(isByte), .result(result), .dstWrEn(dstWrEn), .srcResult(srcResult),
  .srcWrEn(srcWrEn), .flagC(flagC), .flagZ(flagZ), .flagN(flagN), .flagV(flagV)
);

// File: tb/tb_wb_alu.sv
module tb_wb_alu;
  import alu_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        valid = 1'b0;
  logic [4:0]  op = '0;
  logic [15:0] dstVal = '0, srcVal = '0;
  logic        isByte = 1'b0;
  logic [7:0]  imm = '0;
  logic        carryIn = 1'b0;
  logic [15:0] result, srcResult;
  logic        dstWrEn, srcWrEn, flagC, flagZ, flagN, flagV;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit mC = 0, mZ = 0, mN = 0, mV = 0;

  always #2 clk = ~clk;

  wb_alu dut (
    .clk(clk), .rstN(rstN), .valid(valid), .op(op), .dstVal(dstVal), .srcVal(srcVal),
    .isByte(isByte), .imm(imm), .carryIn(carryIn), .result(result), .dstWrEn(dstWrEn),
    .srcResult(srcResult), .srcWrEn(srcWrEn),
    .flagC(flagC), .flagZ(flagZ), .flagN(flagN), .flagV(flagV)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tagOf(input int o);
    if (o <= 1) return "R1";
    if (o <= 3) return "R2";
    if (o == 6) return "R7";
    if (o <= 8) return "R6";
    if (o == 9 || o == 10) return "R11";
    if (o <= 12) return "R8";
    if (o <= 14) return "R9";
    return "R10";
  endfunction

  // Behavioural reference: returns written value, strobes and next flags.
  task automatic model(input int o, input int d, input int s, input bit isb, input int im,
                       input bit cin, output int res, output int wr, output int swr,
                       inout bit c, inout bit z, inout bit n, inout bit v);
    bit cap = (o <= 12) && (o != 10);
    int w = (cap && isb) ? 8 : 16;
    int mask = (1 << w) - 1;
    int sgn = 1 << (w - 1);
    int a = d & mask;
    int b = s & mask;
    int bb, r;
    bit zn = 0;
    wr = 1; swr = 0; r = 0;
    case (o)
      0, 1, 2, 3: begin
        bb = (o >= 2) ? ((~b) & mask) : b;
        r = a + bb + ((o == 0) ? 0 : (o == 2) ? 1 : int'(cin));
        c = ((r >> w) & 1) != 0;
        r = r & mask;
        v = ((a ^ r) & (bb ^ r) & sgn) != 0;
        zn = 1;
      end
      4: begin r = a ^ b; v = 0; zn = 1; end
      5: begin r = a & b; v = 0; zn = 1; end
      6: begin r = a & b; v = 0; zn = 1; wr = 0; end
      7: begin r = a & ~b & mask; v = 0; zn = 1; end
      8: begin r = a | b; v = 0; zn = 1; end
      9: r = b;
      10: begin r = b; swr = 1; end
      11: begin r = (a >> 1) | (a & sgn); c = (a & 1) != 0; v = 0; zn = 1; end
      12: begin r = (a >> 1) | (cin ? sgn : 0); c = (a & 1) != 0; v = 0; zn = 1; end
      13: r = ((d & 'hFF) << 8) | ((d >> 8) & 'hFF);
      14: begin r = (d & 'h80) ? ('hFF00 | (d & 'hFF)) : (d & 'hFF); v = 0; zn = 1; end
      15: r = (d & 'hFF00) | im;
      16: r = im;
      17: r = 'hFF00 | im;
      default: r = ((im & 'hFF) << 8) | (d & 'hFF);
    endcase
    if (zn) begin
      z = (r == 0);
      n = (r & sgn) != 0;
    end
    if (o <= 12 && o != 10 && w == 8) res = (d & 'hFF00) | r;
    else res = r & 'hFFFF;
  endtask

  task automatic apply(input int o, input int d, input int s, input bit isb,
                       input int im, input bit cin, input bit vld);
    int res, wr, swr;
    bit c = mC, z = mZ, n = mN, v = mV;
    string t = tagOf(o);
    @(negedge clk);
    valid = vld; op = 5'(o); dstVal = 16'(d); srcVal = 16'(s);
    isByte = isb; imm = 8'(im); carryIn = cin;
    model(o, d, s, isb, im, cin, res, wr, swr, c, z, n, v);
    #1;
    if (vld) begin
      if (wr != 0) chk((isb && o <= 12 && o != 10) ? {t, " R5 result"} : {t, " result"},
                       int'(result), res);
      chk({t, " dstWrEn"}, int'(dstWrEn), wr);
      chk({t, " srcWrEn"}, int'(srcWrEn), swr);
      if (swr != 0) chk("R11 srcResult", int'(srcResult), d & 'hFFFF);
      mC = c; mZ = z; mN = n; mV = v;
    end else begin
      chk("R13 idle dstWrEn", int'(dstWrEn), 0);
      chk("R13 idle srcWrEn", int'(srcWrEn), 0);
    end
    @(posedge clk);
    #1;
    chk({(o <= 3 || o == 11 || o == 12) ? t : "R12", " flagC"}, int'(flagC), int'(mC));
    chk("R4 flagZ", int'(flagZ), int'(mZ));
    chk("R4 flagN", int'(flagN), int'(mN));
    chk("R3 flagV", int'(flagV), int'(mV));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R13 reset flagC", int'(flagC), 0);
    chk("R13 reset flagZ", int'(flagZ), 0);
    chk("R13 reset flagN", int'(flagN), 0);
    chk("R13 reset flagV", int'(flagV), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R1 carry boundaries at both widths, R3 overflow boundaries
    apply(0, 'hFFFF, 'h0001, 0, 0, 0, 1);
    apply(0, 'h12FF, 'h0001, 1, 0, 0, 1);
    apply(0, 'h7FFF, 'h0001, 0, 0, 0, 1);
    apply(0, 'hAB7F, 'h0001, 1, 0, 0, 1);
    apply(1, 'h00FE, 'h0001, 1, 0, 1, 1);
    // R2 subtract equal operands, borrow, carry variant
    apply(2, 'h1234, 'h1234, 0, 0, 0, 1);
    apply(2, 'h0000, 'h0001, 0, 0, 0, 1);
    apply(3, 'h8000, 'h0001, 0, 0, 0, 1);
    apply(3, 'h5580, 'h0001, 1, 0, 1, 1);
    // R6 R7 logic ops, carry preserved
    apply(4, 'hF0F0, 'hFF00, 0, 0, 0, 1);
    apply(6, 'h00F0, 'h000F, 0, 0, 0, 1);
    apply(7, 'hFFFF, 'h00FF, 1, 0, 0, 1);
    apply(8, 'h8000, 'h0001, 0, 0, 0, 1);
    // R8 shifts
    apply(11, 'h8001, 0, 0, 0, 0, 1);
    apply(11, 'h3381, 0, 1, 0, 0, 1);
    apply(12, 'h0001, 0, 0, 0, 1, 1);
    apply(12, 'hAA02, 0, 1, 0, 1, 1);
    // R9 word-only operations
    apply(13, 'h12AB, 0, 1, 0, 0, 1);
    apply(14, 'h0080, 0, 1, 0, 0, 1);
    apply(14, 'hFF7F, 0, 0, 0, 0, 1);
    // R10 byte-immediate variants
    apply(15, 'hABCD, 0, 0, 'h5A, 0, 1);
    apply(16, 'hABCD, 0, 0, 'h5A, 0, 1);
    apply(17, 'h0000, 0, 0, 'h00, 0, 1);
    apply(18, 'hABCD, 0, 0, 'h5A, 0, 1);
    // R11 move and exchange, R12 flags hold
    apply(9, 'hFFFF, 'h1234, 1, 0, 0, 1);
    apply(10, 'h1111, 'h2222, 0, 0, 0, 1);
    // R13 idle with operands that would change things
    apply(0, 'hFFFF, 'hFFFF, 0, 0, 1, 0);

    for (int i = 0; i < 3000; i++) begin
      int o = $urandom_range(0, 18);
      int d = $urandom_range(0, 'hFFFF);
      int s = $urandom_range(0, 'hFFFF);
      if ((i % 7) == 0) s = d;
      if ((i % 11) == 0) d = 'h7FFF;
      apply(o, d, s, bit'($urandom_range(0, 1)), $urandom_range(0, 255),
            bit'($urandom_range(0, 1)), ($urandom_range(0, 9) != 0));
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule